// File: doc/BRIEF.md
# Prioritised UART interrupt identification

This block decides which interrupt a 16550-style serial controller reports to the host. Its inputs are the software-written enable mask, the receiver overrun flag, the number of characters waiting in the receive queue and a flag that says a modem status line has changed. It also watches three host access strobes: a write to the transmit data register, a write to the enable register and a read of the identification register. From these it produces the identification byte, the enable byte as the host reads it back, and a level interrupt line.

Four causes compete for the identification field. Each one counts only while its enable bit is set, and the highest-ranked enabled cause is reported. Three of the causes follow their inputs directly. The transmitter-empty cause is a latch held inside the block. A data write sets it, and so does a 0-to-1 change of its enable bit. A read of the identification register clears it, but only when transmitter-empty is the cause being reported at that moment. The line status decoder, the receive queue and the bus adapter sit outside the block and connect through the ports below.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable byte reads 0x00, the transmitter-empty latch is clear, the identification byte reads 0x01 (with FIFO mode off) and the interrupt line is low.
- R2: A write to the enable register stores bits 3:0 of the written value. Bits 7:4 always read back as zero. The new value is visible from the cycle after the write strobe.
- R3: When more than one enabled cause is active, the reported code is chosen by rank. Line status (code 0x6) ranks highest, then received data (0xC), then transmitter empty (0x2), then modem change (0x0).
- R4: A cause is reported only while its enable bit is set. Bit 0 enables received data, bit 1 transmitter empty, bit 2 line status and bit 3 modem change. With no enabled cause active, bits 3:0 read 0x1.
- R5: Received data is reported with code 0xC whenever the receive count is non-zero, for any non-zero value, including the largest.
- R6: Every data-register write sets the transmitter-empty latch from the next cycle.
- R7: A write to the enable register that takes bit 1 from 0 to 1 sets the latch. A write that leaves bit 1 at 1 does not set it.
- R8: An identification read clears the latch when code 0x2 is being reported in that cycle. An identification read has no effect on the latch while a higher cause hides it.
- R9: Bits 7:6 of the identification byte are both 1 while FIFO mode is on and both 0 otherwise. Bits 5:4 are always 0.
- R10: The interrupt line is high exactly when the reported code is not 0x1. It follows the inputs and the stored state with no extra delay.
- R11: When a set event (data write or enable edge) falls in the same cycle as a clearing identification read, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_wr | input | 1 | Host write to the transmit data register |
| en_wr | input | 1 | Host write to the enable register |
| en_wdata | input | 8 | Value written to the enable register |
| ident_rd | input | 1 | Host read of the identification register |
| fifo_on | input | 1 | FIFO mode is enabled |
| overrun | input | 1 | Receiver overrun flag |
| rx_count | input | RXC_W | Characters waiting in the receive queue |
| modem_chg | input | 1 | Some modem status delta is set |
| en_rdata | output | 8 | Enable byte as read by the host |
| ident_rdata | output | 8 | Identification byte |
| irq | output | 1 | Level interrupt request |

## Verification
The identification byte and the interrupt line are combinational outputs of the stored enable mask, the stored latch and the live inputs. The bench therefore compares them one time unit after it drives the inputs, in the same cycle. Effects of the strobes (a new enable value, a latch set or cleared) appear only after the next rising edge. The behavioural model applies them at that edge, so the next cycle's comparison is the one that catches a late or missing update. Every cycle is compared against the model, and the last cycle of each stimulus phase carries that phase's requirement tag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    CAUSE_MODEM = 4'h0,
    CAUSE_NONE  = 4'h1,
    CAUSE_TXE   = 4'h2,
    CAUSE_LINE  = 4'h6,
    CAUSE_RXTO  = 4'hC
  } cause_e;

  localparam int EN_W     = 4;
  localparam int EN_RX    = 0;
  localparam int EN_TXE   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // Ranked selection: the first enabled, active cause wins.
  function automatic cause_e pick_cause(input logic [EN_W-1:0] en,
                                        input logic line_act,
                                        input logic rx_act,
                                        input logic txe_act,
                                        input logic modem_act);
    cause_e c;
    c = CAUSE_NONE;
    if (modem_act && en[EN_MODEM]) c = CAUSE_MODEM;
    if (txe_act   && en[EN_TXE])   c = CAUSE_TXE;
    if (rx_act    && en[EN_RX])    c = CAUSE_RXTO;
    if (line_act  && en[EN_LINE])  c = CAUSE_LINE;
    return c;
  endfunction

  function automatic logic [7:0] build_ident(input cause_e c, input logic fifo_mode);
    return {fifo_mode, fifo_mode, 2'b00, c};
  endfunction

endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import uart_irq_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  output logic [EN_W-1:0]  en_q,
  output logic             txe_rise
);

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (wr) en_q <= wdata[EN_W-1:0];
  end

  assign txe_rise = wr && !en_q[EN_TXE] && wdata[EN_TXE];

endmodule

// File: rtl/txe_pending_latch.sv
module txe_pending_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wr,
  input  logic set_edge,
  input  logic clr_rd,
  output logic pend
);

  logic set_any;
  assign set_any = set_wr || set_edge;

  always_ff @(posedge clk) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_any) pend <= 1'b1;
    else if (clr_rd)  pend <= 1'b0;
  end

endmodule

// File: rtl/irq_priority_sel.sv
module irq_priority_sel
  import uart_irq_pkg::*;
#(
  parameter int RXC_W = 5
) (
  input  logic [EN_W-1:0]  en,
  input  logic             overrun,
  input  logic [RXC_W-1:0] rx_count,
  input  logic             txe_pend,
  input  logic             modem_chg,
  input  logic             fifo_on,
  output cause_e           cause,
  output logic [7:0]       ident,
  output logic             irq,
  output logic             txe_shown
);

  logic rx_act;
  assign rx_act    = |rx_count;
  assign cause     = pick_cause(en, overrun, rx_act, txe_pend, modem_chg);
  assign ident     = build_ident(cause, fifo_on);
  assign irq       = (cause != CAUSE_NONE);
  assign txe_shown = (cause == CAUSE_TXE);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int RXC_W = 5,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic             en_wr,
  input  logic [BUS_W-1:0] en_wdata,
  input  logic             ident_rd,
  input  logic             fifo_on,
  input  logic             overrun,
  input  logic [RXC_W-1:0] rx_count,
  input  logic             modem_chg,
  output logic [BUS_W-1:0] en_rdata,
  output logic [7:0]       ident_rdata,
  output logic             irq
);

  localparam int PAD_W = BUS_W - EN_W;

  logic [EN_W-1:0] en_q;
  logic            txe_rise;
  logic            txe_pend;
  logic            txe_shown;
  logic            txe_clr;
  cause_e          cause;

  irq_enable_reg #(.BUS_W(BUS_W)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata),
    .en_q(en_q), .txe_rise(txe_rise)
  );

  assign txe_clr = ident_rd && txe_shown;

  txe_pending_latch u_pend (
    .clk(clk), .rst_n(rst_n), .set_wr(data_wr), .set_edge(txe_rise),
    .clr_rd(txe_clr), .pend(txe_pend)
  );

  irq_priority_sel #(.RXC_W(RXC_W)) u_sel (
    .en(en_q), .overrun(overrun), .rx_count(rx_count), .txe_pend(txe_pend),
    .modem_chg(modem_chg), .fifo_on(fifo_on), .cause(cause),
    .ident(ident_rdata), .irq(irq), .txe_shown(txe_shown)
  );

  assign en_rdata = {{PAD_W{1'b0}}, en_q};

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_wr,
  input logic             en_wr,
  input logic [BUS_W-1:0] en_wdata,
  input logic             ident_rd,
  input logic             fifo_on,
  input logic             overrun,
  input logic [BUS_W-1:0] en_rdata,
  input logic [7:0]       ident_rdata,
  input logic             irq,
  input logic             txe_pend
);

  assert_en_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en_rdata == {4'h0, $past(en_wdata[3:0])});

  assert_line_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && en_rdata[2]) |-> ident_rdata[3:0] == 4'h6);

  assert_data_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> txe_pend);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_rd && ident_rdata[3:0] == 4'h2 && !data_wr &&
     !(en_wr && en_wdata[1] && !en_rdata[1])) |=> !txe_pend);

  assert_fifo_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ident_rdata[7:4] == {fifo_on, fifo_on, 2'b00});

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ident_rdata[3:0] != 4'h1));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.BUS_W(BUS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .en_wr(en_wr),
  .en_wdata(en_wdata), .ident_rd(ident_rd), .fifo_on(fifo_on),
  .overrun(overrun), .en_rdata(en_rdata), .ident_rdata(ident_rdata),
  .irq(irq), .txe_pend(txe_pend)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  localparam int CLK_PERIOD = 10;
  localparam int RXC_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_wr = 1'b0, en_wr = 1'b0, ident_rd = 1'b0;
  logic [7:0] en_wdata = '0;
  logic fifo_on = 1'b0, overrun = 1'b0, modem_chg = 1'b0;
  logic [RXC_W-1:0] rx_count = '0;
  logic [7:0] en_rdata, ident_rdata;
  logic irq;

  int vectors = 0;
  int miscompares = 0;
  int m_en = 0;
  bit m_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident #(.RXC_W(RXC_W)) i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .en_wr(en_wr),
    .en_wdata(en_wdata), .ident_rd(ident_rd), .fifo_on(fifo_on),
    .overrun(overrun), .rx_count(rx_count), .modem_chg(modem_chg),
    .en_rdata(en_rdata), .ident_rdata(ident_rdata), .irq(irq)
  );

  function automatic int exp_code();
    if (overrun && m_en[2]) return 6;
    if (rx_count != 0 && m_en[0]) return 12;
    if (m_pend && m_en[1]) return 2;
    if (modem_chg && m_en[3]) return 0;
    return 1;
  endfunction

  task automatic check(input string tag);
    int code;
    int exp_ident;
    code = exp_code();
    exp_ident = (fifo_on ? 192 : 0) + code;
    vectors++;
    if (int'(ident_rdata) != exp_ident) begin
      miscompares++;
      $display("FAIL %s ident actual=%02h expected=%02h", tag, ident_rdata, exp_ident);
    end
    if (int'(en_rdata) != m_en) begin
      miscompares++;
      $display("FAIL %s enable actual=%02h expected=%02h", tag, en_rdata, m_en);
    end
    if (irq != (code != 1)) begin
      miscompares++;
      $display("FAIL %s/R10 irq actual=%0b expected=%0b", tag, irq, code != 1);
    end
  endtask

  task automatic model_edge();
    bit np;
    if (!rst_n) begin
      m_en = 0; m_pend = 0;
    end else begin
      np = m_pend;
      if (ident_rd && exp_code() == 2) np = 0;
      if (data_wr) np = 1;
      if (en_wr && !m_en[1] && en_wdata[1]) np = 1;
      m_pend = np;
      if (en_wr) m_en = en_wdata % 16;
    end
  endtask

  // Inputs are set by the caller after a falling edge; compare, then advance.
  task automatic step(input string tag);
    #1;
    check(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr_en(input logic [7:0] v, input string tag);
    en_wr = 1'b1; en_wdata = v;
    step(tag);
    en_wr = 1'b0;
  endtask

  task automatic wr_data(input string tag);
    data_wr = 1'b1;
    step(tag);
    data_wr = 1'b0;
  endtask

  task automatic rd_ident(input string tag);
    ident_rd = 1'b1;
    step(tag);
    ident_rd = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected<5000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R1");
    step("R1");
    rst_n = 1'b1;
    step("R1");
    step("R1");

    // R2: only the low nibble is kept
    wr_en(8'hF0, "R2");
    step("R2");
    wr_en(8'hA5, "R2");
    step("R2");
    wr_en(8'h00, "R2");

    // R4: all causes active but nothing enabled
    overrun = 1; rx_count = 3; modem_chg = 1;
    wr_data("R4");
    step("R4");
    wr_en(8'h08, "R4");
    step("R4");
    wr_en(8'h00, "R4");

    // R3: full ranking walk-down
    wr_en(8'h0F, "R3");
    step("R3");
    overrun = 0; step("R3");
    rx_count = 0; step("R3");
    rd_ident("R8");
    step("R3");
    modem_chg = 0; step("R3");

    // R5: any non-zero count
    rx_count = 1; step("R5");
    rx_count = '1; step("R5");
    rx_count = 0; step("R5");

    // R6: data write raises transmitter empty
    wr_en(8'h02, "R6");
    rd_ident("R6");
    step("R6");
    wr_data("R6");
    step("R6");
    rd_ident("R8");
    step("R8");

    // R7: rewriting bit1 = 1 does not re-arm, a fresh edge does
    wr_en(8'h02, "R7");
    step("R7");
    wr_en(8'h00, "R7");
    wr_en(8'h02, "R7");
    step("R7");

    // R8: hidden by a higher cause, the read leaves the latch alone
    wr_en(8'h03, "R8");
    rx_count = 2;
    rd_ident("R8");
    rx_count = 0;
    step("R8");
    rd_ident("R8");
    step("R8");

    // R11: set and clear together
    wr_data("R11");
    data_wr = 1; ident_rd = 1;
    step("R11");
    data_wr = 0; ident_rd = 0;
    step("R11");
    rd_ident("R11");
    step("R11");

    // R9: FIFO mode bits
    fifo_on = 1; step("R9");
    modem_chg = 1; wr_en(8'h08, "R9");
    step("R9");
    fifo_on = 0; step("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule